// File: doc/BRIEF.md
# Security Attribution Access Checker

This block sits between a processor's address stage and the system bus. Every access request carries an address, an access kind (instruction fetch, data read or data write) and the processor's current security state. Two attribution sources are consulted at the same time: a table of programmable regions, and a fixed address map that is chosen at design time. Each source gives the address one of three attributes: non-secure, non-secure-callable or secure. The two answers are merged so that the stricter one wins. The merged attribute is then checked against a per-state policy.

An access that passes the check is forwarded to the bus side over a valid/ready stream. An access that fails never appears on the bus side. It is consumed at once and produces a one-cycle fault pulse. The pulse comes with the address, the security state and the access kind of the access that was refused. A non-secure fetch that lands in a callable region is allowed only if it carries the gateway instruction word, and the block flags that fetch as a legal entry into the secure state. A separate query port returns the merged attribute of any address without making an access.

Back-pressure rules are as follows. The upstream handshake completes when `in_valid` and `in_ready` are both high. For a legal access, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`, so the request waits until the bus accepts it. For a refused access, `in_ready` is high whatever `out_ready` is, and `out_valid` stays low.

Top module: `sa_access_checker`

## Requirements
- R1: After reset every region entry is disabled, `fault_pulse` is 0, and an address that the fixed map marks non-secure reports secure (2'b10) on `tt_attr`.
- R2: An enabled region entry covers the 32-byte granules from `cfg_base` to `cfg_limit`, both included. It gives non-secure (2'b00), or non-secure-callable (2'b01) when its callable bit is set. An address covered by no enabled entry is secure (2'b10).
- R3: When enabled entries overlap, the entry with the lowest index decides the table's attribute.
- R4: The fixed map marks [FIX_S_BASE, FIX_S_LIMIT] secure and [FIX_NSC_BASE, FIX_NSC_LIMIT] callable, and every other address non-secure.
- R5: The merged attribute is the larger of the two codes (non-secure 00 < callable 01 < secure 10). A less secure source never lowers a secure answer.
- R6: In the secure state (`in_secure`=1), data reads (`in_type`=2'b01) and data writes (2'b10) are legal to any address.
- R7: In the secure state, a fetch (`in_type`=2'b00) is legal only when the merged attribute is secure or callable.
- R8: In the non-secure state, data accesses are legal only when the merged attribute is non-secure.
- R9: In the non-secure state, a fetch is legal to a non-secure address. A fetch to a callable address is legal only when `in_insn` equals GW_WORD, and such a fetch raises `gw_entry` together with `out_valid`. Every other non-secure fetch is refused.
- R10: A refused access leaves `out_valid` low, sees `in_ready` high, and raises `fault_pulse` for exactly the following cycle, carrying its address, state and type.
- R11: A legal access drives `out_valid` high with its fields passed through, and `in_ready` equals `out_ready`.
- R12: A region write takes effect at the clock edge only when both `cfg_we` and `cfg_secure` are 1. A write made with `cfg_secure`=0 leaves the table unchanged.
- R13: The query port returns the merged attribute of `tt_addr` and causes neither a bus request nor a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Access request valid |
| in_ready | output | 1 | Access request accepted |
| in_addr | input | ADDR_W | Access address |
| in_type | input | 2 | 00 fetch, 01 read, 10 write |
| in_secure | input | 1 | Processor is in the secure state |
| in_insn | input | 32 | Fetched word, compared against the gateway word |
| out_valid | output | 1 | Forwarded access valid |
| out_ready | input | 1 | Bus accepts forwarded access |
| out_addr | output | ADDR_W | Forwarded address |
| out_type | output | 2 | Forwarded access type |
| out_secure | output | 1 | Forwarded security state |
| gw_entry | output | 1 | Legal non-secure entry through a gateway |
| fault_pulse | output | 1 | One-cycle secure fault request |
| fault_addr | output | ADDR_W | Address of refused access |
| fault_secure | output | 1 | State of refused access |
| fault_type | output | 2 | Type of refused access |
| cfg_we | input | 1 | Region write strobe |
| cfg_secure | input | 1 | Writer is in the secure state |
| cfg_idx | input | IDX_W | Region index |
| cfg_base | input | ADDR_W-GRAN_BITS | First granule of region |
| cfg_limit | input | ADDR_W-GRAN_BITS | Last granule of region |
| cfg_en | input | 1 | Region enable |
| cfg_nsc | input | 1 | Region is non-secure-callable |
| tt_addr | input | ADDR_W | Query address |
| tt_attr | output | 2 | Merged attribute of query address |

## Verification
The bench builds the block with its defaults: eight regions, a 32-bit address, 32-byte granules, a secure fixed window at 0x1000_0000 to 0x1FFF_FFFF and a callable fixed window at 0x0000_F000 to 0x0000_FFFF. Eight entries are enough to program a base-only region, two regions that overlap at different indices and a callable region. They also allow regions that lie over both fixed windows, so the bench can watch the merge both raise a region to callable and keep a region secure. Because the granule is 32 bytes, the last byte of a limit granule and the first byte after it can both be probed.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic [1:0] {
    ATTR_NS  = 2'b00,
    ATTR_NSC = 2'b01,
    ATTR_S   = 2'b10
  } attr_t;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10
  } acc_t;

  // stricter code wins: S > NSC > NS
  function automatic attr_t attr_merge(attr_t a, attr_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sa_region_table.sv
module sa_region_table #(
  parameter int NUM_REGIONS = 8,
  parameter int PW          = 27,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic                           cfg_secure,
  input  logic [IDX_W-1:0]               cfg_idx,
  input  logic [PW-1:0]                  cfg_base,
  input  logic [PW-1:0]                  cfg_limit,
  input  logic                           cfg_en,
  input  logic                           cfg_nsc,
  output logic [NUM_REGIONS-1:0]         reg_en,
  output logic [NUM_REGIONS-1:0]         reg_nsc,
  output logic [NUM_REGIONS-1:0][PW-1:0] reg_base,
  output logic [NUM_REGIONS-1:0][PW-1:0] reg_limit
);
  logic wr_ok;
  assign wr_ok = cfg_we && cfg_secure;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_en[g]    <= 1'b0;
        reg_nsc[g]   <= 1'b0;
        reg_base[g]  <= '0;
        reg_limit[g] <= '0;
      end else if (wr_ok && (cfg_idx == IDX_W'(g))) begin
        reg_en[g]    <= cfg_en;
        reg_nsc[g]   <= cfg_nsc;
        reg_base[g]  <= cfg_base;
        reg_limit[g] <= cfg_limit;
      end
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_secure) |=> ($stable(reg_en) && $stable(reg_nsc)
                                 && $stable(reg_base) && $stable(reg_limit))); // R12
endmodule

// File: rtl/sa_region_match.sv
module sa_region_match
  import sa_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int PW          = 27
) (
  input  logic [PW-1:0]                  addr_hi,
  input  logic [NUM_REGIONS-1:0]         reg_en,
  input  logic [NUM_REGIONS-1:0]         reg_nsc,
  input  logic [NUM_REGIONS-1:0][PW-1:0] reg_base,
  input  logic [NUM_REGIONS-1:0][PW-1:0] reg_limit,
  output attr_t                          attr
);
  logic [NUM_REGIONS-1:0] hit;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_hit
    assign hit[g] = reg_en[g] && (addr_hi >= reg_base[g]) && (addr_hi <= reg_limit[g]);
  end

  // walk from highest index down so the lowest index overrides
  always_comb begin
    attr = ATTR_S;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit[i]) attr = reg_nsc[i] ? ATTR_NSC : ATTR_NS;
    end
  end
endmodule

// File: rtl/sa_fixed_map.sv
module sa_fixed_map
  import sa_pkg::*;
#(
  parameter int                ADDR_W        = 32,
  parameter logic [ADDR_W-1:0] FIX_S_BASE    = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] FIX_S_LIMIT   = 32'h1FFF_FFFF,
  parameter logic [ADDR_W-1:0] FIX_NSC_BASE  = 32'h0000_F000,
  parameter logic [ADDR_W-1:0] FIX_NSC_LIMIT = 32'h0000_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output attr_t             attr
);
  logic in_s, in_nsc;
  assign in_s   = (addr >= FIX_S_BASE)   && (addr <= FIX_S_LIMIT);
  assign in_nsc = (addr >= FIX_NSC_BASE) && (addr <= FIX_NSC_LIMIT);

  always_comb begin
    if (in_s)        attr = ATTR_S;
    else if (in_nsc) attr = ATTR_NSC;
    else             attr = ATTR_NS;
  end
endmodule

// File: rtl/sa_policy.sv
module sa_policy
  import sa_pkg::*;
#(
  parameter logic [31:0] GW_WORD = 32'hA5C3_0F1E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_secure,
  input  logic [1:0]  acc_type,
  input  logic [31:0] acc_insn,
  input  attr_t       attr,
  output logic        legal,
  output logic        gw_hit
);
  logic is_fetch;
  assign is_fetch = (acc_type == ACC_FETCH);

  always_comb begin
    gw_hit = 1'b0;
    if (acc_secure) begin
      legal = is_fetch ? (attr != ATTR_NS) : 1'b1;
    end else if (attr == ATTR_NS) begin
      legal = 1'b1;
    end else begin
      gw_hit = is_fetch && (attr == ATTR_NSC) && (acc_insn == GW_WORD);
      legal  = gw_hit;
    end
  end

  AST_NS_DATA_ONLY_NS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && legal && !acc_secure && !is_fetch) |-> (attr == ATTR_NS)); // R8
  AST_S_FETCH_NOT_NS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && legal && acc_secure && is_fetch) |-> (attr != ATTR_NS)); // R7
endmodule

// File: rtl/sa_access_checker.sv
module sa_access_checker
  import sa_pkg::*;
#(
  parameter int                ADDR_W        = 32,
  parameter int                NUM_REGIONS   = 8,
  parameter int                GRAN_BITS     = 5,
  parameter logic [ADDR_W-1:0] FIX_S_BASE    = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] FIX_S_LIMIT   = 32'h1FFF_FFFF,
  parameter logic [ADDR_W-1:0] FIX_NSC_BASE  = 32'h0000_F000,
  parameter logic [ADDR_W-1:0] FIX_NSC_LIMIT = 32'h0000_FFFF,
  parameter logic [31:0]       GW_WORD       = 32'hA5C3_0F1E,
  localparam int               PW            = ADDR_W - GRAN_BITS,
  localparam int               IDX_W         = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_type,
  input  logic              in_secure,
  input  logic [31:0]       in_insn,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_type,
  output logic              out_secure,
  output logic              gw_entry,
  output logic              fault_pulse,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              fault_secure,
  output logic [1:0]        fault_type,
  input  logic              cfg_we,
  input  logic              cfg_secure,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [PW-1:0]     cfg_base,
  input  logic [PW-1:0]     cfg_limit,
  input  logic              cfg_en,
  input  logic              cfg_nsc,
  input  logic [ADDR_W-1:0] tt_addr,
  output logic [1:0]        tt_attr
);
  logic [NUM_REGIONS-1:0]         reg_en, reg_nsc;
  logic [NUM_REGIONS-1:0][PW-1:0] reg_base, reg_limit;

  sa_region_table #(.NUM_REGIONS(NUM_REGIONS), .PW(PW)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_secure(cfg_secure),
    .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_en(cfg_en), .cfg_nsc(cfg_nsc), .reg_en(reg_en), .reg_nsc(reg_nsc),
    .reg_base(reg_base), .reg_limit(reg_limit)
  );

  // lookup port 0: live access, port 1: test-target query
  logic  [1:0][ADDR_W-1:0] look_addr;
  attr_t [1:0]             tbl_attr, fix_attr, mrg_attr;
  assign look_addr[0] = in_addr;
  assign look_addr[1] = tt_addr;

  for (genvar p = 0; p < 2; p++) begin : g_look
    sa_region_match #(.NUM_REGIONS(NUM_REGIONS), .PW(PW)) u_match (
      .addr_hi(look_addr[p][ADDR_W-1:GRAN_BITS]), .reg_en(reg_en), .reg_nsc(reg_nsc),
      .reg_base(reg_base), .reg_limit(reg_limit), .attr(tbl_attr[p])
    );
    sa_fixed_map #(.ADDR_W(ADDR_W), .FIX_S_BASE(FIX_S_BASE), .FIX_S_LIMIT(FIX_S_LIMIT),
                   .FIX_NSC_BASE(FIX_NSC_BASE), .FIX_NSC_LIMIT(FIX_NSC_LIMIT)) u_fixed (
      .addr(look_addr[p]), .attr(fix_attr[p])
    );
    assign mrg_attr[p] = attr_merge(tbl_attr[p], fix_attr[p]);
  end

  logic legal, gw_hit;
  sa_policy #(.GW_WORD(GW_WORD)) u_policy (
    .clk(clk), .rst_n(rst_n), .acc_valid(in_valid), .acc_secure(in_secure),
    .acc_type(in_type), .acc_insn(in_insn), .attr(mrg_attr[0]),
    .legal(legal), .gw_hit(gw_hit)
  );

  assign out_valid  = in_valid && legal;
  assign in_ready   = legal ? out_ready : 1'b1;
  assign out_addr   = in_addr;
  assign out_type   = in_type;
  assign out_secure = in_secure;
  assign gw_entry   = out_valid && gw_hit;
  assign tt_attr    = mrg_attr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_pulse  <= 1'b0;
      fault_addr   <= '0;
      fault_secure <= 1'b0;
      fault_type   <= '0;
    end else begin
      fault_pulse <= in_valid && !legal;
      if (in_valid && !legal) begin
        fault_addr   <= in_addr;
        fault_secure <= in_secure;
        fault_type   <= in_type;
      end
    end
  end

  AST_BLOCKED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_valid) |=> fault_pulse); // R10
  AST_FAULT_FROM_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> $past(in_valid && !out_valid)); // R10
  AST_STRICT_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((tbl_attr[1] == ATTR_S) || (fix_attr[1] == ATTR_S)) |-> (tt_attr == 2'b10)); // R5
  AST_GW_ONLY_NS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    gw_entry |-> (!in_secure && (in_type == 2'b00) && (in_insn == GW_WORD))); // R9
  AST_NS_NEVER_SECURE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_secure) |-> (mrg_attr[0] != ATTR_S)); // R8
endmodule

// File: tb/sim_sa_access_checker.sv
module sim_sa_access_checker;
  localparam logic [31:0] GW = 32'hA5C3_0F1E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_secure = 1'b0, out_ready = 1'b1;
  logic [31:0] in_addr = '0, in_insn = '0, tt_addr = '0;
  logic [1:0]  in_type = 2'b01;
  logic        cfg_we = 1'b0, cfg_secure = 1'b0, cfg_en = 1'b0, cfg_nsc = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [26:0] cfg_base = '0, cfg_limit = '0;
  logic        in_ready, out_valid, out_secure, gw_entry;
  logic        fault_pulse, fault_secure;
  logic [31:0] out_addr, fault_addr;
  logic [1:0]  out_type, fault_type, tt_attr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sa_access_checker u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_type(in_type), .in_secure(in_secure), .in_insn(in_insn),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_type(out_type), .out_secure(out_secure), .gw_entry(gw_entry),
    .fault_pulse(fault_pulse), .fault_addr(fault_addr), .fault_secure(fault_secure),
    .fault_type(fault_type), .cfg_we(cfg_we), .cfg_secure(cfg_secure),
    .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_en(cfg_en), .cfg_nsc(cfg_nsc), .tt_addr(tt_addr), .tt_attr(tt_attr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_region(input int idx, input logic [31:0] lo, input logic [31:0] hi,
                              input bit en, input bit nsc, input bit sec);
    @(negedge clk);
    cfg_we = 1'b1; cfg_secure = sec; cfg_idx = 3'(idx);
    cfg_base = lo[31:5]; cfg_limit = hi[31:5]; cfg_en = en; cfg_nsc = nsc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic query(input logic [31:0] a, input logic [1:0] exp, input string req);
    @(negedge clk);
    tt_addr = a;
    #1;
    chk(tt_attr == exp, req, {30'd0, tt_attr}, {30'd0, exp});
    chk(!out_valid && !fault_pulse, req, {31'd0, out_valid | fault_pulse}, 32'd0);
  endtask

  // drive one access, check the handshake, then the fault pulse window
  task automatic access(input bit sec, input logic [1:0] typ, input logic [31:0] a,
                        input logic [31:0] insn, input bit exp_ok, input bit exp_gw,
                        input string req);
    @(negedge clk);
    in_valid = 1'b1; in_secure = sec; in_type = typ; in_addr = a; in_insn = insn;
    out_ready = 1'b1;
    #1;
    chk(out_valid == exp_ok, req, {31'd0, out_valid}, {31'd0, exp_ok});
    chk(in_ready == 1'b1, req, {31'd0, in_ready}, 32'd1);
    chk(gw_entry == exp_gw, req, {31'd0, gw_entry}, {31'd0, exp_gw});
    if (exp_ok) chk(out_addr == a && out_type == typ && out_secure == sec, req, out_addr, a);
    @(posedge clk); #1;
    chk(fault_pulse == !exp_ok, req, {31'd0, fault_pulse}, {31'd0, !exp_ok});
    if (!exp_ok) chk(fault_addr == a && fault_type == typ && fault_secure == sec,
                     "R10", fault_addr, a);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk(fault_pulse == 1'b0, "R10", {31'd0, fault_pulse}, 32'd0);
  endtask

  task automatic t_reset;
    #1;
    chk(fault_pulse == 1'b0, "R1", {31'd0, fault_pulse}, 32'd0);
    query(32'h2000_0000, 2'b10, "R1");
    query(32'h5000_0000, 2'b10, "R1");
  endtask

  task automatic t_program;
    write_region(0, 32'h2000_0000, 32'h2000_0FFF, 1, 0, 1);
    write_region(1, 32'h0000_0000, 32'h0000_FFFF, 1, 0, 1);
    write_region(2, 32'h3000_0000, 32'h3000_00FF, 1, 1, 1);
    write_region(3, 32'h1000_0000, 32'h1000_0FFF, 1, 0, 1);
    write_region(4, 32'h2000_0800, 32'h2000_08FF, 1, 1, 1);
    write_region(5, 32'h4000_0000, 32'h4000_001F, 1, 1, 1);
    write_region(6, 32'h4000_0000, 32'h4000_001F, 1, 0, 1);
  endtask

  task automatic t_region_lookup;
    query(32'h2000_0000, 2'b00, "R2 base");
    query(32'h2000_0FFF, 2'b00, "R2 limit last byte");
    query(32'h2000_1000, 2'b10, "R2 past limit");
    query(32'h3000_0010, 2'b01, "R2 nsc");
  endtask

  task automatic t_overlap;
    query(32'h2000_0840, 2'b00, "R3 idx0 over idx4");
    query(32'h4000_0010, 2'b01, "R3 idx5 over idx6");
  endtask

  task automatic t_merge;
    query(32'h0000_F100, 2'b01, "R4 R5 fixed nsc raises");
    query(32'h1000_0010, 2'b10, "R4 R5 fixed secure wins");
    query(32'h0000_0100, 2'b00, "R4 both ns");
  endtask

  task automatic t_cfg_lock;
    write_region(0, 32'h0, 32'h0, 0, 0, 0);
    query(32'h2000_0000, 2'b00, "R12 ns write ignored");
    write_region(7, 32'h5000_0000, 32'h5000_001F, 1, 0, 0);
    query(32'h5000_0000, 2'b10, "R12 ns write ignored");
    write_region(7, 32'h5000_0000, 32'h5000_001F, 1, 0, 1);
    query(32'h5000_0000, 2'b00, "R12 secure write lands");
  endtask

  task automatic t_secure_policy;
    access(1, 2'b01, 32'h1000_0010, 32'h0, 1, 0, "R6 s read secure");
    access(1, 2'b10, 32'h2000_0000, 32'h0, 1, 0, "R6 s write ns");
    access(1, 2'b00, 32'h2000_0000, 32'h0, 0, 0, "R7 s fetch ns");
    access(1, 2'b00, 32'h3000_0010, 32'h0, 1, 0, "R7 s fetch nsc");
    access(1, 2'b00, 32'h1000_0010, 32'h0, 1, 0, "R7 s fetch s");
  endtask

  task automatic t_nonsecure_policy;
    access(0, 2'b01, 32'h2000_0000, 32'h0, 1, 0, "R8 ns read ns");
    access(0, 2'b10, 32'h1000_0010, 32'h0, 0, 0, "R8 ns write s");
    access(0, 2'b01, 32'h3000_0010, GW,    0, 0, "R8 ns read nsc");
    access(0, 2'b00, 32'h2000_0000, 32'h0, 1, 0, "R9 ns fetch ns");
  endtask

  task automatic t_gateway;
    access(0, 2'b00, 32'h3000_0010, GW,           1, 1, "R9 gateway word");
    access(0, 2'b00, 32'h3000_0010, 32'h1234_5678, 0, 0, "R9 wrong word");
    access(0, 2'b00, 32'h1000_0010, GW,           0, 0, "R9 gateway into s");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    in_valid = 1'b1; in_secure = 1'b1; in_type = 2'b01; in_addr = 32'h2000_0040;
    out_ready = 1'b0;
    #1;
    chk(out_valid && !in_ready, "R11 stall", {30'd0, out_valid, in_ready}, 32'd2);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk(out_valid && in_ready, "R11 release", {30'd0, out_valid, in_ready}, 32'd3);
    @(negedge clk);
    out_ready = 1'b0; in_secure = 1'b0; in_addr = 32'h1000_0000;
    #1;
    chk(!out_valid && in_ready, "R10 refusal ignores stall", {30'd0, out_valid, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk); #1;
    chk(fault_pulse == 1'b0, "R10", {31'd0, fault_pulse}, 32'd0);
  endtask

  task automatic t_query_side_effects;
    query(32'h1000_0000, 2'b10, "R13 query no access");
    @(posedge clk); #1;
    chk(!fault_pulse && !out_valid, "R13", {31'd0, fault_pulse}, 32'd0);
  endtask

  initial begin
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_region_lookup();
    t_overlap();
    t_merge();
    t_cfg_lock();
    t_secure_policy();
    t_nonsecure_policy();
    t_gateway();
    t_backpressure();
    t_query_side_effects();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule